// File: doc/BRIEF.md
# Temperature Conversion Sequencer

This block decides when the temperature converter runs and holds the result that the rest of the sensor sees. In normal operation it starts a conversion at a fixed period, derived from a clock-frequency parameter. When either the shutdown bit or the single-conversion bit is set, it stops the periodic schedule and turns off converter power. It then runs exactly one conversion for each trigger strobe and powers down again once that conversion ends.

The converter sits behind a start/done handshake. A single-cycle start pulse launches a conversion. The converter later raises done for one cycle with the result. At that point the block copies the result into the stored temperature register in one step and emits a one-cycle sample-valid strobe for the limit-compare logic. The stored value changes at no other time, so a bus read taken while a conversion runs returns the previous result.

Top module: `tconv_sequencer`

## Requirements
- R1: While rst_ni is low, conv_start_o, sample_vld_o and pwr_en_o are 0 and temp_o is 0x0000.
- R2: In normal mode (cfg_shdn_i = 0 and cfg_oneshot_i = 0), the first conv_start_o pulse follows the first clock edge after reset release. Later pulses come exactly PERIOD_MS × CLK_HZ / 1000 cycles apart.
- R3: conv_start_o is never high for two consecutive cycles, and it never pulses while a conversion is outstanding.
- R4: A conv_done_i seen while a conversion is outstanding loads temp_o on the next cycle with the result left-justified: conv_data_i in the upper DATA_W bits and zeros below. sample_vld_o is high for that one cycle.
- R5: temp_o changes only in a cycle where sample_vld_o is high. While a conversion is running, temp_o keeps the previous result.
- R6: In low-power mode (cfg_shdn_i = 1 or cfg_oneshot_i = 1), no periodic conversion starts. pwr_en_o is 0 on the cycle after entry if no conversion is running, and temp_o keeps its last value.
- R7: In low-power mode, an os_trig_i pulse seen while idle produces conv_start_o with pwr_en_o high on the next cycle. pwr_en_o stays high until the cycle in which sample_vld_o rises, when it returns to 0.
- R8: An os_trig_i pulse that arrives while a conversion is running is ignored: no extra start and no extra sample.
- R9: When low-power mode ends, the periodic timer restarts. A conversion starts on the cycle after the mode bit clears, and the next one follows one full period later.
- R10: os_trig_i has no effect in normal mode.
- R11: A conv_done_i that arrives when no conversion is outstanding is ignored. temp_o does not change and sample_vld_o stays 0.
- R12: In normal mode, pwr_en_o stays high between conversions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_shdn_i | input | 1 | Shutdown configuration bit |
| cfg_oneshot_i | input | 1 | Single-conversion mode configuration bit |
| os_trig_i | input | 1 | Single-conversion trigger strobe (a write to the trigger register) |
| conv_start_o | output | 1 | One-cycle start pulse to the converter |
| conv_done_i | input | 1 | Converter result-ready strobe |
| conv_data_i | input | DATA_W | Converter result, two's complement |
| temp_o | output | 16 | Stored temperature, left-justified two's complement |
| sample_vld_o | output | 1 | One-cycle strobe to the limit logic when temp_o updates |
| pwr_en_o | output | 1 | Converter power enable |

## Verification
The bench measures the spacing of periodic starts cycle by cycle, both after reset and after leaving low-power mode. A timer that failed to restart, or that was off by one on its wrap, would shift these starts and be caught. It reads the stored value in the middle of a conversion, and it watches temp_o on every cycle for a change without a sample strobe, so a register that tracked the converter bus or updated early is detected. It sends a second trigger during a running conversion, a trigger in normal mode and a stray done while idle, each of which would show up as an extra start or sample. It also checks that power drops in the same cycle the single-conversion result lands, and one cycle after shutdown is entered.

// File: rtl/tconv_pkg.sv
package tconv_pkg;
  localparam int unsigned TEMP_W = 16;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } tconv_st_e;
endpackage

// File: rtl/tconv_period_timer.sv
module tconv_period_timer #(
  parameter int unsigned PERIOD_CYC = 80
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CNT_W = (PERIOD_CYC > 2) ? $clog2(PERIOD_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  // held at zero outside normal mode so leaving low power restarts the period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!run_i)      cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/tconv_ctrl.sv
module tconv_ctrl
  import tconv_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lp_i,
  input  logic tick_i,
  input  logic trig_i,
  input  logic done_i,
  output logic start_o,
  output logic run_o,
  output logic pwr_o,
  output logic capture_o
);
  tconv_st_e st_q, st_d;
  logic      go;
  logic      start_q, pwr_q;

  assign run_o     = (st_q == ST_RUN);
  assign go        = (st_q == ST_IDLE) && (lp_i ? trig_i : tick_i);
  assign capture_o = run_o && done_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (go)     st_d = ST_RUN;
      ST_RUN:  if (done_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      start_q <= 1'b0;
      pwr_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      start_q <= go;
      // powered in normal mode, or from launch until the result lands
      pwr_q   <= !lp_i || go || (run_o && !done_i);
    end
  end

  assign start_o = start_q;
  assign pwr_o   = pwr_q;
endmodule

// File: rtl/tconv_result.sv
module tconv_result
  import tconv_pkg::*;
#(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [TEMP_W-1:0] temp_o,
  output logic              vld_o
);
  localparam int unsigned PAD_W = (TEMP_W > DATA_W) ? TEMP_W - DATA_W : 0;

  logic [DATA_W-1:0] temp_q;
  logic              vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      temp_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= capture_i;
      if (capture_i) temp_q <= data_i;
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign temp_o = {temp_q, {PAD_W{1'b0}}};
    end else begin : g_full
      assign temp_o = temp_q[DATA_W-1 -: TEMP_W];
    end
  endgenerate

  assign vld_o = vld_q;
endmodule

// File: rtl/tconv_sequencer.sv
module tconv_sequencer
  import tconv_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 125_000_000,
  parameter int unsigned PERIOD_MS = 80,
  parameter int unsigned DATA_W    = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_shdn_i,
  input  logic              cfg_oneshot_i,
  input  logic              os_trig_i,
  output logic              conv_start_o,
  input  logic              conv_done_i,
  input  logic [DATA_W-1:0] conv_data_i,
  output logic [TEMP_W-1:0] temp_o,
  output logic              sample_vld_o,
  output logic              pwr_en_o
);
  localparam int unsigned PERIOD_CYC = (CLK_HZ / 1000) * PERIOD_MS;

  logic lp_mode;
  logic tick;
  logic run_q;
  logic capture;

  assign lp_mode = cfg_shdn_i || cfg_oneshot_i;

  tconv_period_timer #(.PERIOD_CYC(PERIOD_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (!lp_mode),
    .tick_o (tick)
  );

  tconv_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lp_i      (lp_mode),
    .tick_i    (tick),
    .trig_i    (os_trig_i),
    .done_i    (conv_done_i),
    .start_o   (conv_start_o),
    .run_o     (run_q),
    .pwr_o     (pwr_en_o),
    .capture_o (capture)
  );

  tconv_result #(.DATA_W(DATA_W)) u_result (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture),
    .data_i    (conv_data_i),
    .temp_o    (temp_o),
    .vld_o     (sample_vld_o)
  );
endmodule

// File: rtl/tconv_sequencer_chk.sv
module tconv_sequencer_chk #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned TEMP_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lp_mode,
  input logic              run_q,
  input logic              os_trig_i,
  input logic              conv_start_o,
  input logic              conv_done_i,
  input logic [DATA_W-1:0] conv_data_i,
  input logic [TEMP_W-1:0] temp_o,
  input logic              sample_vld_o,
  input logic              pwr_en_o
);
  // R3
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);

  // R8
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !conv_done_i) |=> !conv_start_o);

  // R4
  capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && conv_done_i) |=>
      (sample_vld_o && temp_o[TEMP_W-1 -: DATA_W] == $past(conv_data_i)));

  // R5
  coherent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(run_q && conv_done_i) |=> ($stable(temp_o) && !sample_vld_o));

  // R6
  power_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_mode && !run_q && !os_trig_i) |=> !pwr_en_o);

  // R7
  power_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> pwr_en_o);

  // R9
  resume_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lp_mode && $past(lp_mode) && !run_q) |=> conv_start_o);
endmodule

bind tconv_sequencer tconv_sequencer_chk #(.DATA_W(DATA_W), .TEMP_W(tconv_pkg::TEMP_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .lp_mode      (lp_mode),
  .run_q        (run_q),
  .os_trig_i    (os_trig_i),
  .conv_start_o (conv_start_o),
  .conv_done_i  (conv_done_i),
  .conv_data_i  (conv_data_i),
  .temp_o       (temp_o),
  .sample_vld_o (sample_vld_o),
  .pwr_en_o     (pwr_en_o)
);

// File: tb/sim_tconv_sequencer.sv
`timescale 1ns/1ps
module sim_tconv_sequencer;
  localparam int unsigned CLK_HZ   = 1000;
  localparam int unsigned PER_MS   = 80;
  localparam int unsigned PER_CYC  = 80;
  localparam int unsigned DW       = 12;
  localparam int         CONV_LAT = 20;
  localparam int         WD_LIMIT = 20000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_shdn = 1'b0, cfg_os = 1'b0, trig = 1'b0;
  logic stub_done = 1'b0, man_done = 1'b0;
  logic [DW-1:0] stub_val = '0, stub_data = '0, man_data = '0;
  logic conv_start, sample_vld, pwr_en;
  logic [15:0] temp;

  int n_chk = 0, n_err = 0;
  int cyc = 0, start_cnt = 0, vld_cnt = 0, last_start = 0, prev_start = 0;
  int dbl = 0, coh_err = 0, lat = 0;
  logic prev_st = 1'b0;
  logic [15:0] prev_temp = '0;
  bit finished = 0;

  always #4 clk = ~clk;

  tconv_sequencer #(.CLK_HZ(CLK_HZ), .PERIOD_MS(PER_MS), .DATA_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_shdn_i(cfg_shdn), .cfg_oneshot_i(cfg_os),
    .os_trig_i(trig), .conv_start_o(conv_start), .conv_done_i(stub_done | man_done),
    .conv_data_i(man_done ? man_data : stub_data), .temp_o(temp),
    .sample_vld_o(sample_vld), .pwr_en_o(pwr_en));

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // monitor, converter stub and watchdog, run just after each rising edge
  always @(posedge clk) begin
    #2;
    cyc++;
    if (conv_start) begin
      start_cnt++; prev_start = last_start; last_start = cyc;
      if (prev_st) dbl++;
    end
    prev_st = conv_start;
    if (sample_vld) vld_cnt++;
    if (rst_ni && temp !== prev_temp && !sample_vld) coh_err++;
    prev_temp = temp;
    stub_done = 1'b0;
    if (lat > 0) begin
      lat--;
      if (lat == 0) begin stub_done = 1'b1; stub_data = stub_val; end
    end
    if (conv_start) lat = CONV_LAT;
    if (cyc >= WD_LIMIT && !finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog (all requirements): got hang expected finish by cycle %0d", WD_LIMIT);
      summary();
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_vld();
    int v0 = vld_cnt;
    while (vld_cnt == v0) @(negedge clk);
  endtask

  task automatic wait_start();
    int s0 = start_cnt;
    while (start_cnt == s0) @(negedge clk);
  endtask

  task automatic pulse_trig();
    trig = 1'b1; @(negedge clk); trig = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1", "start in reset", conv_start, 0);
    chk("R1", "vld in reset", sample_vld, 0);
    chk("R1", "pwr in reset", pwr_en, 0);
    chk("R1", "temp in reset", temp, 0);
  endtask

  task automatic t_periodic();
    stub_val = 12'h190;
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R2", "first start after reset", conv_start, 1);
    chk("R12", "pwr in normal", pwr_en, 1);
    wait_vld();
    chk("R4", "temp after done", temp, 16'h1900);
    @(negedge clk);
    chk("R4", "vld is one cycle", sample_vld, 0);
    chk("R12", "pwr idle in normal", pwr_en, 1);
    stub_val = 12'hE70;
    wait_start();
    repeat (5) @(negedge clk);
    chk("R5", "temp mid conversion", temp, 16'h1900);
    wait_vld();
    chk("R4", "negative result", temp, 16'hE700);
    wait_start();
    chk("R2", "period spacing", last_start - prev_start, PER_CYC);
    wait_vld();
  endtask

  task automatic t_trig_normal();
    int s0 = start_cnt;
    pulse_trig();
    repeat (10) @(negedge clk);
    chk("R10", "trigger in normal mode", start_cnt - s0, 0);
  endtask

  task automatic t_shutdown();
    int s0;
    logic [15:0] t0 = temp;
    cfg_shdn = 1'b1;
    @(negedge clk);
    chk("R6", "pwr after shutdown", pwr_en, 0);
    s0 = start_cnt;
    repeat (200) @(negedge clk);
    chk("R6", "no periodic start", start_cnt - s0, 0);
    chk("R6", "temp retained", temp, t0);
    chk("R6", "pwr stays off", pwr_en, 0);
  endtask

  task automatic t_stray_done();
    int v0 = vld_cnt;
    logic [15:0] t0 = temp;
    man_data = 12'h555; man_done = 1'b1;
    @(negedge clk); man_done = 1'b0;
    @(negedge clk);
    chk("R11", "vld after stray done", vld_cnt - v0, 0);
    chk("R11", "temp after stray done", temp, t0);
  endtask

  task automatic t_oneshot();
    stub_val = 12'h7D0;
    pulse_trig();
    chk("R7", "start after trigger", conv_start, 1);
    chk("R7", "pwr at start", pwr_en, 1);
    repeat (3) @(negedge clk);
    chk("R7", "pwr during run", pwr_en, 1);
    wait_vld();
    chk("R7", "pwr off as result lands", pwr_en, 0);
    chk("R4", "one-shot result", temp, 16'h7D00);
  endtask

  task automatic t_trig_busy();
    int s0, v0;
    cfg_shdn = 1'b0; cfg_os = 1'b1;
    @(negedge clk);
    s0 = start_cnt; v0 = vld_cnt;
    stub_val = 12'hC90;
    pulse_trig();
    repeat (5) @(negedge clk);
    pulse_trig();
    wait_vld();
    repeat (30) @(negedge clk);
    chk("R8", "starts for two triggers", start_cnt - s0, 1);
    chk("R8", "samples for two triggers", vld_cnt - v0, 1);
    chk("R4", "result in one-shot mode", temp, 16'hC900);
  endtask

  task automatic t_resume();
    int s0;
    cfg_os = 1'b0;
    @(negedge clk);
    chk("R9", "start on resume", conv_start, 1);
    s0 = last_start;
    wait_start();
    chk("R9", "period after resume", last_start - s0, PER_CYC);
  endtask

  initial begin
    t_reset();
    t_periodic();
    t_trig_normal();
    t_shutdown();
    t_stray_done();
    t_oneshot();
    t_trig_busy();
    t_resume();
    repeat (2) @(negedge clk);
    chk("R3", "back-to-back starts", dbl, 0);
    chk("R5", "temp change without strobe", coh_err, 0);
    finished = 1;
    summary();
  end
endmodule